// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control around a successive-approximation converter core. It holds a control register that is loaded by a single write strobe. It starts conversions from that write or from a hardware trigger input, and it tracks whether a single or a continuous run is in flight. When the core reports a finished conversion, the block rounds the raw 12-bit code to the selected 12, 10 or 8 bit width. It can screen the rounded value against a compare threshold, then stores it in a high/low result register pair and raises a completion flag and, when enabled, an interrupt.

It also derives the converter clock as a one-cycle enable pulse. The source is picked from four options and divided by 1, 2, 4 or 8. The analog core sits outside: the block only pulses `core_start` and samples `core_done` with `core_result`. The stored result leaves through a valid/ready pair. `res_valid` is the completion flag, and a cycle with both `res_valid` and `res_ready` high consumes the result and drops the flag. There is no back-pressure on the core side. A new result that lands while the previous one is still unconsumed overwrites it and keeps `res_valid` high.

The hardware trigger is asynchronous. It passes through a two-stage synchronizer, and only its rising edge counts.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the stored configuration is bus clock, divide by 1, 12-bit mode, with every enable clear. `res_hi`, `res_lo`, `res_valid`, `irq`, `busy` and `core_start` are all 0.
- R2: `adck_tick` pulses once per 1, 2, 4 or 8 source ticks for clock divide codes 0, 1, 2 and 3. The clock select codes are: 0 = every bus cycle, 1 = every second bus cycle, 2 = `alt_tick`, 3 = `async_tick`.
- R3: A cycle with `ctl_wr` high and `ctl_hw_en` low starts a conversion. `core_start` and `busy` are 1 in the next cycle.
- R4: With the hardware enable stored, a rising edge on `hw_trig` launches a conversion through a two-stage synchronizer. A write with `ctl_hw_en` high launches nothing, and edges that arrive while `busy` is 1 are ignored.
- R5: In continuous mode, each accepted `core_done` pulses `core_start` in the next cycle with `busy` held at 1, and no further trigger edge is needed.
- R6: In 12-bit mode (mode code 0, and also code 3), `res_hi` takes raw bits 11:8 and `res_lo` takes raw bits 7:0.
- R7: In 10-bit mode (mode code 1), the stored value is (raw+2)>>2, saturated at 1023. Bits 9:8 go to `res_hi[1:0]` and bits 7:0 go to `res_lo`.
- R8: In 8-bit mode (mode code 2), `res_lo` takes (raw+8)>>4, saturated at 255, and `res_hi` keeps its previous value.
- R9: `res_valid` rises in the cycle after an accepted `core_done`. It clears after a cycle with `res_valid` and `res_ready` both high, or after any `ctl_wr`. `irq` is `res_valid` while the stored interrupt enable is 1, and 0 otherwise.
- R10: With compare enabled, only a rounded result that is greater than `cmp_val` (compare select 1) or less than `cmp_val` (select 0) is stored. The comparison uses the selected width. A failing result changes no register and does not set `res_valid`.
- R11: A `ctl_wr` aborts any conversion in flight. A `core_done` that arrives while `busy` is 0 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control register write strobe (loads config, aborts, may start) |
| ctl_cont | input | 1 | Continuous conversion enable |
| ctl_hw_en | input | 1 | Hardware trigger enable |
| ctl_mode | input | 2 | Result width: 0/3 = 12, 1 = 10, 2 = 8 bits |
| ctl_ien | input | 1 | Interrupt enable |
| ctl_cmp_en | input | 1 | Compare enable |
| ctl_cmp_gt | input | 1 | Compare select: 1 keeps greater, 0 keeps less |
| ctl_clk_sel | input | 2 | Converter clock source select |
| ctl_clk_div | input | 2 | Converter clock divide code |
| cmp_val | input | 12 | Compare threshold, right-justified in selected width |
| hw_trig | input | 1 | Asynchronous hardware trigger |
| alt_tick | input | 1 | Alternate clock source tick |
| async_tick | input | 1 | Internal asynchronous clock source tick |
| adck_tick | output | 1 | Converter clock enable pulse |
| core_start | output | 1 | One-cycle start pulse to the converter core |
| core_done | input | 1 | Conversion finished pulse from the core |
| core_result | input | 12 | Raw result from the core |
| res_valid | output | 1 | Conversion-complete flag / result valid |
| res_ready | input | 1 | Result consumer ready |
| res_hi | output | 4 | High result register |
| res_lo | output | 8 | Low result register |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Conversion in flight |

## Verification
The bench targets the rounding boundaries. Raw codes 0xFFE and 0xFF9 must saturate instead of wrapping, so a design that drops the carry would store 0 or a small value. Codes 5, 6, 0x17 and 0x18 sit on either side of the half-LSB point, so a truncating design would store one less. It sends trigger edges while a single conversion is busy and while a continuous run is active. A design that re-armed on those edges would show an extra `core_start`. It checks that 8-bit results leave the high register untouched. It checks that a compare failure at equality in 8-bit mode discards the result: comparing the unrounded raw code or using a non-strict comparison would store it. A `core_done` arriving after an aborting write must be dropped, not stored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_10 = 2'd1,
    RES_8  = 2'd2,
    RES_12B = 2'd3
  } res_mode_e;

  typedef enum logic [1:0] {
    SRC_BUS   = 2'd0,
    SRC_HALF  = 2'd1,
    SRC_ALT   = 2'd2,
    SRC_ASYNC = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic      cont;
    logic      hw_en;
    res_mode_e mode;
    logic      ien;
    logic      cmp_en;
    logic      cmp_gt;
    clk_src_e  clk_sel;
    logic [1:0] clk_div;
  } ctl_cfg_t;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
  import adc_seq_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_src_e         sel,
  input  logic [DIV_W-1:0] div,
  input  logic             alt_tick,
  input  logic             async_tick,
  output logic             adck_tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic             half_q;
  logic             src_tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  always_comb begin
    unique case (sel)
      SRC_BUS:   src_tick = 1'b1;
      SRC_HALF:  src_tick = half_q;
      SRC_ALT:   src_tick = alt_tick;
      default:   src_tick = async_tick;
    endcase
  end

  // thermometer limit: 2**div - 1
  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(div));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      adck_tick <= 1'b0;
    end else begin
      adck_tick <= 1'b0;
      if (src_tick) begin
        if (cnt_q >= lim) begin
          cnt_q     <= '0;
          adck_tick <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_round_cmp.sv
module adc_round_cmp
  import adc_seq_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input  logic [RAW_W-1:0] raw,
  input  res_mode_e        mode,
  input  logic             cmp_en,
  input  logic             cmp_gt,
  input  logic [RAW_W-1:0] cmp_val,
  output logic [RAW_W-1:0] res,
  output logic             keep
);
  localparam int D10 = RAW_W - 10;
  localparam int D8  = RAW_W - 8;

  logic [RAW_W:0] sum10, sum8;
  logic [9:0]     r10;
  logic [7:0]     r8;

  always_comb begin
    sum10 = {1'b0, raw} + ((RAW_W+1)'(1) << (D10 - 1));
    sum8  = {1'b0, raw} + ((RAW_W+1)'(1) << (D8 - 1));
    r10   = sum10[RAW_W] ? '1 : sum10[RAW_W-1:D10];
    r8    = sum8[RAW_W]  ? '1 : sum8[RAW_W-1:D8];
    unique case (mode)
      RES_10:  res = RAW_W'(r10);
      RES_8:   res = RAW_W'(r8);
      default: res = raw;
    endcase
    if (!cmp_en)     keep = 1'b1;
    else if (cmp_gt) keep = (res > cmp_val);
    else             keep = (res < cmp_val);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RAW_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_cont,
  input  logic             ctl_hw_en,
  input  logic [1:0]       ctl_mode,
  input  logic             ctl_ien,
  input  logic             ctl_cmp_en,
  input  logic             ctl_cmp_gt,
  input  logic [1:0]       ctl_clk_sel,
  input  logic [DIV_W-1:0] ctl_clk_div,
  input  logic [RAW_W-1:0] cmp_val,
  input  logic             hw_trig,
  input  logic             alt_tick,
  input  logic             async_tick,
  output logic             adck_tick,
  output logic             core_start,
  input  logic             core_done,
  input  logic [RAW_W-1:0] core_result,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RAW_W-9:0] res_hi,
  output logic [7:0]       res_lo,
  output logic             irq,
  output logic             busy
);
  localparam int HI_W = RAW_W - 8;

  ctl_cfg_t         cfg_q;
  ctl_cfg_t         cfg_new;
  logic             trig_rise;
  logic [RAW_W-1:0] rnd_res;
  logic             rnd_keep;
  logic             accept;

  assign cfg_new = '{cont: ctl_cont, hw_en: ctl_hw_en, mode: res_mode_e'(ctl_mode),
                     ien: ctl_ien, cmp_en: ctl_cmp_en, cmp_gt: ctl_cmp_gt,
                     clk_sel: clk_src_e'(ctl_clk_sel), clk_div: 2'(ctl_clk_div)};

  adc_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .sel(cfg_q.clk_sel), .div(DIV_W'(cfg_q.clk_div)),
    .alt_tick(alt_tick), .async_tick(async_tick), .adck_tick(adck_tick)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(hw_trig), .rise(trig_rise)
  );

  adc_round_cmp #(.RAW_W(RAW_W)) u_rnd (
    .raw(core_result), .mode(cfg_q.mode), .cmp_en(cfg_q.cmp_en),
    .cmp_gt(cfg_q.cmp_gt), .cmp_val(cmp_val), .res(rnd_res), .keep(rnd_keep)
  );

  assign accept = core_done && busy && !ctl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      busy       <= 1'b0;
      core_start <= 1'b0;
      res_valid  <= 1'b0;
      res_hi     <= '0;
      res_lo     <= '0;
    end else if (ctl_wr) begin
      cfg_q      <= cfg_new;
      busy       <= !cfg_new.hw_en;
      core_start <= !cfg_new.hw_en;
      res_valid  <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (accept) begin
        if (rnd_keep) begin
          res_valid <= 1'b1;
          res_lo    <= rnd_res[7:0];
          if (cfg_q.mode != RES_8) res_hi <= rnd_res[RAW_W-1:8];
        end
        if (cfg_q.cont) core_start <= 1'b1;
        else            busy       <= 1'b0;
      end else if (!busy && cfg_q.hw_en && trig_rise) begin
        busy       <= 1'b1;
        core_start <= 1'b1;
      end
    end
  end

  assign irq = res_valid && cfg_q.ien;

  if (HI_W < 2) begin : g_width_guard
    initial $error("RAW_W must be at least 10");
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             ctl_hw_en,
  input ctl_cfg_t         cfg_q,
  input logic             busy,
  input logic             core_start,
  input logic             core_done,
  input logic             res_valid,
  input logic [RAW_W-9:0] res_hi,
  input logic [7:0]       res_lo,
  input logic             irq,
  input logic             adck_tick
);
  p_bus_div1_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cfg_q.clk_sel) == SRC_BUS && $past(cfg_q.clk_div) == 2'd0 |-> adck_tick);

  p_sw_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_hw_en |=> core_start && busy);

  p_start_only_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && core_start |-> $past(ctl_wr) || !$past(busy) || $past(core_done));

  p_cont_relaunch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && busy && !ctl_wr && cfg_q.cont |=> core_start && busy);

  p_ten_bit_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && busy && !ctl_wr && cfg_q.mode == RES_10 |=> (res_hi >> 2) == '0);

  p_eight_bit_hi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && busy && !ctl_wr && cfg_q.mode == RES_8 |=> $stable(res_hi));

  p_wr_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !res_valid);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> res_valid);

  p_idle_done_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && !busy && !ctl_wr |=> $stable(res_lo) && $stable(res_hi) && !$rose(res_valid));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RAW_W(RAW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_hw_en(ctl_hw_en), .cfg_q(cfg_q),
  .busy(busy), .core_start(core_start), .core_done(core_done), .res_valid(res_valid),
  .res_hi(res_hi), .res_lo(res_lo), .irq(irq), .adck_tick(adck_tick)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_cont = 0, ctl_hw_en = 0, ctl_ien = 0, ctl_cmp_en = 0, ctl_cmp_gt = 0;
  logic [1:0] ctl_mode = 0, ctl_clk_sel = 0, ctl_clk_div = 0;
  logic [11:0] cmp_val = 0, core_result = 0;
  logic hw_trig = 0, alt_tick = 0, async_tick = 0, core_done = 0, res_ready = 0;
  logic adck_tick, core_start, res_valid, irq, busy;
  logic [3:0] res_hi;
  logic [7:0] res_lo;
  int n_chk = 0, n_fail = 0, tcount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl u_dut (.*);

  always @(negedge clk) begin
    tcount++;
    alt_tick   = (tcount % 4 == 0);
    async_tick = (tcount % 2 == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit cont, input bit hw, input int mode, input bit ien,
                     input bit cen, input bit cgt, input int sel, input int div);
    ctl_cont = cont; ctl_hw_en = hw; ctl_mode = 2'(mode); ctl_ien = ien;
    ctl_cmp_en = cen; ctl_cmp_gt = cgt; ctl_clk_sel = 2'(sel); ctl_clk_div = 2'(div);
  endtask

  task automatic pulse_wr();
    @(negedge clk) ctl_wr = 1;
    @(negedge clk) ctl_wr = 0;
  endtask

  task automatic finish(input int raw);
    core_result = 12'(raw); core_done = 1;
    @(negedge clk) core_done = 0;
  endtask

  task automatic conv(input int raw);
    pulse_wr();
    finish(raw);
  endtask

  task automatic wait_start(input int lim, output bit found);
    found = 0;
    for (int i = 0; i < lim; i++) begin
      if (core_start) begin found = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (adck_tick) n++;
    end
  endtask

  task automatic t_reset();
    int n;
    check("R1 res_valid", res_valid, 0);
    check("R1 res_hi", res_hi, 0);
    check("R1 res_lo", res_lo, 0);
    check("R1 irq", irq, 0);
    check("R1 busy", busy, 0);
    check("R1 core_start", core_start, 0);
    count_ticks(n);
    check("R1 default bus clock div1 ticks", n, 64);
  endtask

  task automatic t_clock();
    int n;
    cfg(0, 1, 0, 0, 0, 0, 1, 2); pulse_wr(); count_ticks(n);
    check("R2 half bus div4 ticks ok", int'(n >= 7 && n <= 9), 1);
    cfg(0, 1, 0, 0, 0, 0, 0, 3); pulse_wr(); count_ticks(n);
    check("R2 bus div8 ticks ok", int'(n >= 7 && n <= 9), 1);
    cfg(0, 1, 0, 0, 0, 0, 2, 1); pulse_wr(); count_ticks(n);
    check("R2 alt div2 ticks ok", int'(n >= 7 && n <= 9), 1);
    cfg(0, 1, 0, 0, 0, 0, 3, 0); pulse_wr(); count_ticks(n);
    check("R2 async div1 ticks ok", int'(n >= 31 && n <= 33), 1);
    check("R4 hw-enabled write starts nothing", busy, 0);
  endtask

  task automatic t_sw12();
    cfg(0, 0, 0, 1, 0, 0, 0, 0);
    pulse_wr();
    check("R3 core_start after write", core_start, 1);
    check("R3 busy after write", busy, 1);
    finish('hABC);
    check("R9 valid after done", res_valid, 1);
    check("R6 res_hi", res_hi, 'hA);
    check("R6 res_lo", res_lo, 'hBC);
    check("R9 irq enabled", irq, 1);
    check("R3 busy cleared single", busy, 0);
    repeat (3) @(negedge clk);
    check("R9 valid held without ready", res_valid, 1);
    res_ready = 1;
    @(negedge clk) res_ready = 0;
    check("R9 valid cleared by handshake", res_valid, 0);
    check("R9 irq cleared", irq, 0);
  endtask

  task automatic t_round10();
    cfg(0, 0, 1, 0, 0, 0, 0, 0);
    conv('hFFE);
    check("R7 saturate hi", res_hi, 3);
    check("R7 saturate lo", res_lo, 'hFF);
    conv(6);
    check("R7 round up hi", res_hi, 0);
    check("R7 round up lo", res_lo, 2);
    conv(5);
    check("R7 round down lo", res_lo, 1);
  endtask

  task automatic t_round8();
    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    conv('h5A5);
    check("R6 preload hi", res_hi, 5);
    cfg(0, 0, 2, 0, 0, 0, 0, 0);
    conv('h017);
    check("R8 round down lo", res_lo, 1);
    check("R8 hi untouched", res_hi, 5);
    conv('hFF9);
    check("R8 saturate lo", res_lo, 255);
    check("R8 hi untouched after sat", res_hi, 5);
    conv('h018);
    check("R8 round up lo", res_lo, 2);
  endtask

  task automatic t_cmp();
    cmp_val = 'h800;
    cfg(0, 0, 0, 0, 1, 1, 0, 0);
    conv('h900);
    check("R10 greater kept valid", res_valid, 1);
    check("R10 greater kept hi", res_hi, 9);
    conv('h7FF);
    check("R10 not greater discarded valid", res_valid, 0);
    check("R10 not greater regs kept", res_hi, 9);
    cfg(0, 0, 0, 0, 1, 0, 0, 0);
    conv('h7FF);
    check("R10 less kept lo", res_lo, 'hFF);
    check("R10 less kept hi", res_hi, 7);
    cmp_val = 'h080;
    cfg(0, 0, 2, 0, 1, 1, 0, 0);
    conv('h808);
    check("R10 8-bit greater kept", res_lo, 'h81);
    conv('h7F8);
    check("R10 8-bit equal discarded valid", res_valid, 0);
    check("R10 8-bit equal discarded lo", res_lo, 'h81);
  endtask

  task automatic t_hw();
    bit f;
    cfg(0, 1, 0, 0, 0, 0, 0, 0);
    pulse_wr();
    check("R4 hw write no start", core_start, 0);
    hw_trig = 1;
    wait_start(8, f);
    check("R4 edge launches", f, 1);
    @(negedge clk) hw_trig = 0;
    repeat (4) @(negedge clk);
    hw_trig = 1;
    wait_start(8, f);
    check("R4 edge while busy ignored", f, 0);
    finish('h123);
    check("R4 result stored", res_lo, 'h23);
    check("R9 irq disabled", irq, 0);
    check("R9 valid with irq disabled", res_valid, 1);
    wait_start(6, f);
    check("R4 level without edge no start", f, 0);
    hw_trig = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_cont();
    bit f;
    cfg(1, 1, 0, 0, 0, 0, 0, 0);
    pulse_wr();
    hw_trig = 1;
    wait_start(8, f);
    check("R5 first edge launches", f, 1);
    @(negedge clk) hw_trig = 0;
    finish('h111);
    check("R5 relaunch after done", core_start, 1);
    check("R5 busy held", busy, 1);
    check("R5 first result", res_lo, 'h11);
    @(negedge clk) hw_trig = 1;
    wait_start(8, f);
    check("R5 edge during run ignored", f, 0);
    finish('h222);
    check("R5 second relaunch", core_start, 1);
    check("R5 second result", res_lo, 'h22);
    hw_trig = 0;
    cfg(0, 1, 0, 0, 0, 0, 0, 0);
    pulse_wr();
    check("R11 write aborts run", busy, 0);
    finish('h333);
    check("R11 stray done not stored lo", res_lo, 'h22);
    check("R11 stray done no flag", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clock();
    t_sw12();
    t_round10();
    t_round8();
    t_cmp();
    t_hw();
    t_cont();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule